// File: doc/BRIEF.md
# Skip-Aware Priority Pin Crossbar

The block decides which peripheral signal drives each pin of a linear array of general-purpose pins. Peripheral groups are switched on by enable inputs. Each enabled group adds its signals to a fixed priority list. The decoder walks the pins from index 0 upward and hands each free pin to the next signal that is still waiting in the list. A pin is not free when its skip bit is set, or when it is one of the two pins reserved for the first UART. Pins that receive no signal stay as ordinary GPIO.

The result is computed combinationally from the configuration inputs and registered on the clock. For each pin it presents a function code and an "assigned" flag. If the enabled signals outnumber the free pins, the surplus signals are dropped and a sticky overflow flag is raised. The default array has 25 pins, indexed as port 0 bits 0..7, port 1 bits 0..7, port 2 bits 0..7 and port 3 bit 0. The missing upper bits of port 3 are simply absent from the array.

Top module: `xbar_crossbar_decoder`

## Requirements
- R1: Function codes rank signals by priority, highest first: 1 TX0, 2 RX0, 3 SCK, 4 MISO, 5 MOSI, 6 NSS, 7 SDA, 8 SCL, 9 CP0, 10 CP0A, 11 CP1, 12 CP1A, 13 SYSCLK, 14..18 CEX0..CEX4, 19 ECI, 20 T0, 21 T1, 22 TX1, 23 RX1. Pin i reports its code on pin_func[5*i+4:5*i].
- R2: One enable per UART places both its TX and RX signals. One enable for the two-wire bus places both SDA and SCL. One SPI enable places SCK, MISO and MOSI.
- R3: While uart0_en is 1, pin 4 carries code 1 and pin 4's neighbour pin 5 carries code 2, even when their skip bits are set. Packed signals pass over these two pins. While uart0_en is 0, pins 4 and 5 are ordinary free pins.
- R4: NSS (code 6) is placed only while spi_four_wire is 1. In three-wire mode it takes no pin.
- R5: A pin whose skip_mask bit is 1 never carries a packed signal (code 0).
- R6: A pin that receives no signal reports code 0 and pin_assigned 0. An assigned pin reports pin_assigned 1.
- R7: If there are more packed signals than free pins, the k-th signal still goes to the k-th free pin and the rest are dropped. overflow then becomes 1 and stays 1 until reset.
- R8: Outputs follow the inputs one clock later. A synchronous reset makes every pin code 0, clears every assigned flag and clears overflow.
- R9: pca_outs selects how many of CEX0..CEX4 are placed, from 0 upward. Values above 5 place all five.
- R10: Packing is contiguous: after removing skipped and reserved pins, the k-th pending signal in priority order lands on the k-th remaining pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| uart0_en | input | 1 | Place TX0/RX0 on their fixed pins |
| spi_en | input | 1 | Place SCK, MISO, MOSI |
| spi_four_wire | input | 1 | Also place NSS |
| twb_en | input | 1 | Place SDA and SCL |
| cmp0_en | input | 1 | Place CP0 |
| cmp0_async_en | input | 1 | Place CP0A |
| cmp1_en | input | 1 | Place CP1 |
| cmp1_async_en | input | 1 | Place CP1A |
| sysclk_en | input | 1 | Place SYSCLK |
| pca_outs | input | 3 | Number of CEX outputs to place |
| eci_en | input | 1 | Place ECI |
| t0_en | input | 1 | Place T0 |
| t1_en | input | 1 | Place T1 |
| uart1_en | input | 1 | Place TX1 and RX1 |
| skip_mask | input | 25 | 1 = pin excluded from packing |
| pin_func | output | 125 | Registered 5-bit function code per pin |
| pin_assigned | output | 25 | Registered per-pin assigned flag |
| overflow | output | 1 | Sticky: signals were dropped |

## Verification
The embedded properties assume that every configuration input is synchronous to clk and is held across a whole cycle. Each registered output is then checked against the inputs sampled one edge earlier. The bench changes inputs only on the falling edge, so that assumption holds. The properties also assume that reset is the only way to clear overflow. Any 3-bit pca_outs value is legal, so the stimulus includes values above 5 to exercise the clamp. When the bench leaves reset, it first sets the configuration inputs to all zero. This keeps the first edge after reset from registering an overflow that the scoreboard does not expect.

// File: rtl/xbar_pkg.sv
package xbar_pkg;
   localparam int NFUNC      = 23;
   localparam int PCA_MAX    = 5;
   localparam int CODE_GPIO  = 0;
   localparam int CODE_TX0   = 1;
   localparam int CODE_RX0   = 2;
   localparam int CODE_SCK   = 3;
   localparam int CODE_MISO  = 4;
   localparam int CODE_MOSI  = 5;
   localparam int CODE_NSS   = 6;
   localparam int CODE_SDA   = 7;
   localparam int CODE_SCL   = 8;
   localparam int CODE_CP0   = 9;
   localparam int CODE_CP0A  = 10;
   localparam int CODE_CP1   = 11;
   localparam int CODE_CP1A  = 12;
   localparam int CODE_SYSCK = 13;
   localparam int CODE_CEX0  = 14;
   localparam int CODE_ECI   = 19;
   localparam int CODE_T0    = 20;
   localparam int CODE_T1    = 21;
   localparam int CODE_TX1   = 22;
   localparam int CODE_RX1   = 23;
endpackage

// File: rtl/xbar_request.sv
// Expands group enables into one request bit per function code (R1, R2, R4, R9).
module xbar_request
   import xbar_pkg::*;
#(
   parameter int PCA_W = 3
) (
   input  logic             uart0_en,
   input  logic             spi_en,
   input  logic             spi_four_wire,
   input  logic             twb_en,
   input  logic             cmp0_en,
   input  logic             cmp0_async_en,
   input  logic             cmp1_en,
   input  logic             cmp1_async_en,
   input  logic             sysclk_en,
   input  logic [PCA_W-1:0] pca_outs,
   input  logic             eci_en,
   input  logic             t0_en,
   input  logic             t1_en,
   input  logic             uart1_en,
   output logic [NFUNC:1]   req
);
   logic [PCA_MAX-1:0] cex_req;

   // R9: thermometer decode, values above PCA_MAX saturate
   for (genvar k = 0; k < PCA_MAX; k++) begin : g_cex
      assign cex_req[k] = (pca_outs > PCA_W'(k));
   end

   always_comb begin
      req                 = '0;
      req[CODE_TX0]       = uart0_en;
      req[CODE_RX0]       = uart0_en;
      req[CODE_SCK]       = spi_en;
      req[CODE_MISO]      = spi_en;
      req[CODE_MOSI]      = spi_en;
      req[CODE_NSS]       = spi_en & spi_four_wire;
      req[CODE_SDA]       = twb_en;
      req[CODE_SCL]       = twb_en;
      req[CODE_CP0]       = cmp0_en;
      req[CODE_CP0A]      = cmp0_async_en;
      req[CODE_CP1]       = cmp1_en;
      req[CODE_CP1A]      = cmp1_async_en;
      req[CODE_SYSCK]     = sysclk_en;
      for (int k = 0; k < PCA_MAX; k++) req[CODE_CEX0 + k] = cex_req[k];
      req[CODE_ECI]       = eci_en;
      req[CODE_T0]        = t0_en;
      req[CODE_T1]        = t1_en;
      req[CODE_TX1]       = uart1_en;
      req[CODE_RX1]       = uart1_en;
   end
endmodule

// File: rtl/xbar_packer.sv
// Rank-matching packer: the k-th pending function meets the k-th free pin (R5, R7, R10).
module xbar_packer
   import xbar_pkg::*;
#(
   parameter int NUM_PINS    = 25,
   parameter int CODE_W      = 5,
   parameter int TX0_PIN     = 4,
   parameter int RX0_PIN     = 5,
   parameter bit UART0_FIXED = 1'b1
) (
   input  logic [NFUNC:1]           req,
   input  logic [NUM_PINS-1:0]      skip,
   output logic [NUM_PINS*CODE_W-1:0] code_flat,
   output logic [NUM_PINS-1:0]      hit,
   output logic                     over
);
   localparam int MAXN  = (NFUNC > NUM_PINS) ? NFUNC : NUM_PINS;
   localparam int CNT_W = $clog2(MAXN + 1);

   logic [NFUNC:1]      pack_req;
   logic [NUM_PINS-1:0] reserved;
   logic [NUM_PINS-1:0] free_pin;
   logic [CNT_W-1:0]    rank [1:NFUNC];
   logic [CNT_W-1:0]    slot [NUM_PINS];
   logic [CNT_W-1:0]    n_req;
   logic [CNT_W-1:0]    n_free;

   // Variant: fixed UART0 pins are taken out of the packed list
   if (UART0_FIXED) begin : g_fixed
      always_comb begin
         pack_req           = req;
         pack_req[CODE_TX0] = 1'b0;
         pack_req[CODE_RX0] = 1'b0;
      end
   end else begin : g_packed
      assign pack_req = req;
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_res
      if (UART0_FIXED && i == TX0_PIN) begin : g_tx
         assign reserved[i] = req[CODE_TX0];
      end else if (UART0_FIXED && i == RX0_PIN) begin : g_rx
         assign reserved[i] = req[CODE_RX0];
      end else begin : g_none
         assign reserved[i] = 1'b0;
      end
   end

   assign free_pin = ~skip & ~reserved;

   // Prefix counts over requests (rank) and free pins (slot)
   always_comb begin
      logic [CNT_W-1:0] c;
      c = '0;
      for (int f = 1; f <= NFUNC; f++) begin
         rank[f] = c;
         c       = c + CNT_W'(pack_req[f]);
      end
      n_req = c;
   end

   always_comb begin
      logic [CNT_W-1:0] c;
      c = '0;
      for (int i = 0; i < NUM_PINS; i++) begin
         slot[i] = c;
         c       = c + CNT_W'(free_pin[i]);
      end
      n_free = c;
   end

   assign over = (n_req > n_free);

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      localparam int FIXED_CODE = (i == TX0_PIN) ? CODE_TX0 : CODE_RX0;
      logic [CODE_W-1:0] pcode;
      always_comb begin
         pcode = '0;
         if (reserved[i]) begin
            pcode = CODE_W'(FIXED_CODE);
         end else if (free_pin[i]) begin
            for (int f = 1; f <= NFUNC; f++) begin
               if (pack_req[f] && rank[f] == slot[i]) pcode = CODE_W'(f);
            end
         end
      end
      assign code_flat[i*CODE_W +: CODE_W] = pcode;
      assign hit[i] = reserved[i] | (free_pin[i] & (slot[i] < n_req));
   end
endmodule

// File: rtl/xbar_crossbar_decoder.sv
module xbar_crossbar_decoder
   import xbar_pkg::*;
#(
   parameter int NUM_PINS    = 25,
   parameter int CODE_W      = 5,
   parameter int PCA_W       = 3,
   parameter int TX0_PIN     = 4,
   parameter int RX0_PIN     = 5,
   parameter bit UART0_FIXED = 1'b1
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       uart0_en,
   input  logic                       spi_en,
   input  logic                       spi_four_wire,
   input  logic                       twb_en,
   input  logic                       cmp0_en,
   input  logic                       cmp0_async_en,
   input  logic                       cmp1_en,
   input  logic                       cmp1_async_en,
   input  logic                       sysclk_en,
   input  logic [PCA_W-1:0]           pca_outs,
   input  logic                       eci_en,
   input  logic                       t0_en,
   input  logic                       t1_en,
   input  logic                       uart1_en,
   input  logic [NUM_PINS-1:0]        skip_mask,
   output logic [NUM_PINS*CODE_W-1:0] pin_func,
   output logic [NUM_PINS-1:0]        pin_assigned,
   output logic                       overflow
);
   // Elaboration-time parameter checks
   if (NUM_PINS < 1) begin : g_chk_pins
      $error("NUM_PINS must be positive");
   end
   if ((1 << CODE_W) <= NFUNC) begin : g_chk_code
      $error("CODE_W too narrow for the function list");
   end
   if (UART0_FIXED && (TX0_PIN >= NUM_PINS || RX0_PIN >= NUM_PINS || TX0_PIN == RX0_PIN)) begin : g_chk_uart
      $error("fixed UART0 pins out of range");
   end
   if (PCA_W < 3) begin : g_chk_pca
      $error("PCA_W must encode up to PCA_MAX");
   end

   logic [NFUNC:1]                req;
   logic [NUM_PINS*CODE_W-1:0]    code_d;
   logic [NUM_PINS-1:0]           hit_d;
   logic                          over_d;

   xbar_request #(.PCA_W(PCA_W)) u_req (
      .uart0_en(uart0_en), .spi_en(spi_en), .spi_four_wire(spi_four_wire),
      .twb_en(twb_en), .cmp0_en(cmp0_en), .cmp0_async_en(cmp0_async_en),
      .cmp1_en(cmp1_en), .cmp1_async_en(cmp1_async_en), .sysclk_en(sysclk_en),
      .pca_outs(pca_outs), .eci_en(eci_en), .t0_en(t0_en), .t1_en(t1_en),
      .uart1_en(uart1_en), .req(req)
   );

   xbar_packer #(
      .NUM_PINS(NUM_PINS), .CODE_W(CODE_W), .TX0_PIN(TX0_PIN),
      .RX0_PIN(RX0_PIN), .UART0_FIXED(UART0_FIXED)
   ) u_pack (
      .req(req), .skip(skip_mask), .code_flat(code_d), .hit(hit_d), .over(over_d)
   );

   // R8: registered outputs, synchronous clear; R7: sticky overflow
   always_ff @(posedge clk) begin
      if (rst) begin
         pin_func     <= '0;
         pin_assigned <= '0;
         overflow     <= 1'b0;
      end else begin
         pin_func     <= code_d;
         pin_assigned <= hit_d;
         overflow     <= overflow | over_d;
      end
   end

   assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
      overflow |=> overflow);

   assert_reset_clear_R8: assert property (@(posedge clk)
      $past(rst) === 1'b1 |-> (pin_assigned == '0 && pin_func == '0 && !overflow));

   if (UART0_FIXED) begin : g_a_uart
      assert_uart0_fixed_R3: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && $past(uart0_en)) |->
            (pin_func[TX0_PIN*CODE_W +: CODE_W] == CODE_W'(CODE_TX0) &&
             pin_func[RX0_PIN*CODE_W +: CODE_W] == CODE_W'(CODE_RX0)));
   end

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_a_pin
      assert_flag_code_R6: assert property (@(posedge clk) disable iff (rst)
         pin_assigned[i] == (pin_func[i*CODE_W +: CODE_W] != '0));
      assert_nss_three_wire_R4: assert property (@(posedge clk) disable iff (rst)
         (!$past(rst) && !$past(spi_four_wire)) |->
            pin_func[i*CODE_W +: CODE_W] != CODE_W'(CODE_NSS));
      if (!(UART0_FIXED && (i == TX0_PIN || i == RX0_PIN))) begin : g_skip
         assert_skip_idle_R5: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(skip_mask[i])) |-> pin_func[i*CODE_W +: CODE_W] == '0);
      end
   end
endmodule

// File: tb/sim_xbar_crossbar_decoder.sv
`timescale 1ns/1ps
module sim_xbar_crossbar_decoder;
   localparam int NP = 25;

   typedef struct packed {
      logic uart0, spi, four, twb, c0, c0a, c1, c1a, sclk;
      logic [2:0] pca;
      logic eci, t0, t1, uart1;
      logic [NP-1:0] skip;
   } cfg_t;

   typedef struct {
      logic [NP*5-1:0] f;
      logic [NP-1:0]   a;
      logic            o;
      string           tag;
   } item_t;

   logic clk = 0, rst = 1;
   cfg_t cfg = '0;
   logic [NP*5-1:0] pin_func;
   logic [NP-1:0]   pin_assigned;
   logic            overflow;

   int checks = 0, errors = 0;
   bit done = 0;
   logic exp_ovf = 0;
   item_t q[$];

   always #5 clk = ~clk;

   xbar_crossbar_decoder u0 (
      .clk(clk), .rst(rst), .uart0_en(cfg.uart0), .spi_en(cfg.spi),
      .spi_four_wire(cfg.four), .twb_en(cfg.twb), .cmp0_en(cfg.c0),
      .cmp0_async_en(cfg.c0a), .cmp1_en(cfg.c1), .cmp1_async_en(cfg.c1a),
      .sysclk_en(cfg.sclk), .pca_outs(cfg.pca), .eci_en(cfg.eci), .t0_en(cfg.t0),
      .t1_en(cfg.t1), .uart1_en(cfg.uart1), .skip_mask(cfg.skip),
      .pin_func(pin_func), .pin_assigned(pin_assigned), .overflow(overflow)
   );

   // Independent model: sequential walk over pins with a list pointer
   function automatic void model(input cfg_t c, output logic [NP*5-1:0] f,
                                 output logic [NP-1:0] a, output logic ov);
      int ord[32];
      int n = 0;
      int p = 0;
      int ncex;
      if (c.spi) begin ord[n++] = 3; ord[n++] = 4; ord[n++] = 5; if (c.four) ord[n++] = 6; end
      if (c.twb) begin ord[n++] = 7; ord[n++] = 8; end
      if (c.c0) ord[n++] = 9;
      if (c.c0a) ord[n++] = 10;
      if (c.c1) ord[n++] = 11;
      if (c.c1a) ord[n++] = 12;
      if (c.sclk) ord[n++] = 13;
      ncex = (c.pca > 5) ? 5 : int'(c.pca);
      for (int k = 0; k < ncex; k++) ord[n++] = 14 + k;
      if (c.eci) ord[n++] = 19;
      if (c.t0) ord[n++] = 20;
      if (c.t1) ord[n++] = 21;
      if (c.uart1) begin ord[n++] = 22; ord[n++] = 23; end
      f = '0; a = '0;
      for (int i = 0; i < NP; i++) begin
         if (c.uart0 && i == 4) begin f[i*5 +: 5] = 5'd1; a[i] = 1; end
         else if (c.uart0 && i == 5) begin f[i*5 +: 5] = 5'd2; a[i] = 1; end
         else if (!c.skip[i] && p < n) begin f[i*5 +: 5] = 5'(ord[p]); a[i] = 1; p++; end
      end
      ov = (p < n);
   endfunction

   task automatic drive(input cfg_t c, input string tag);
      item_t it;
      logic o;
      @(negedge clk);
      cfg = c;
      model(c, it.f, it.a, o);
      exp_ovf = exp_ovf | o;
      it.o = exp_ovf;
      it.tag = tag;
      q.push_back(it);
   endtask

   task automatic check(input bit ok, input string tag, input string what,
                        input logic [NP*5-1:0] act, input logic [NP*5-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // Monitor: pops one expected item per edge once the registered result is visible
   always begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
         item_t it;
         it = q.pop_front();
         check(pin_func == it.f, it.tag, "pin_func", pin_func, it.f);
         check(pin_assigned == it.a, it.tag, "pin_assigned", {100'b0, pin_assigned}, {100'b0, it.a});
         check(overflow == it.o, it.tag, "overflow", {124'b0, overflow}, {124'b0, it.o});
      end
   end

   task automatic do_reset(input string tag);
      while (q.size() > 0) @(negedge clk);
      @(negedge clk);
      rst = 1;
      cfg = '0;
      repeat (2) @(negedge clk);
      check(pin_func == '0, tag, "reset pin_func", pin_func, '0);
      check(pin_assigned == '0 && overflow == 0, tag, "reset flags",
            {99'b0, overflow, pin_assigned}, '0);
      exp_ovf = 0;
      rst = 0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      cfg_t c;
      repeat (3) @(negedge clk);
      // R8: reset state
      check(pin_func == '0 && pin_assigned == '0 && overflow == 0, "R8", "reset state",
            pin_func, '0);
      @(negedge clk);
      rst = 0;

      // R2 R3 R4 R5 R10: UART0 + 4-wire SPI + two-wire bus, skips P0.2 P0.3 P1.0
      c = '0; c.uart0 = 1; c.spi = 1; c.four = 1; c.twb = 1;
      c.skip = 25'h0000_10C;
      drive(c, "R10_example");
      c.four = 0;
      drive(c, "R4_three_wire");
      drive('0, "R6_all_gpio");
      // R3: fixed pins override skip bits
      c = '0; c.uart0 = 1; c.skip = 25'h30; drive(c, "R3_skip_override");
      // R3: pins 4/5 free when UART0 off
      c = '0; c.spi = 1; c.four = 1; c.twb = 1; c.c0 = 1; drive(c, "R3_uart0_off");
      // R1 R9: everything, pca clamp
      c = '1; c.skip = '0; c.pca = 3'd7; drive(c, "R1_R9_all");
      c = '0; c.pca = 3'd3; c.t1 = 1; c.uart1 = 1; c.skip = 25'h1; drive(c, "R9_pca3");
      c = '0; c.pca = 3'd5; c.eci = 1; drive(c, "R9_pca5");
      // R7: overflow then sticky
      c = '1; c.pca = 3'd5; c.skip = 25'h1FF_FFF0; drive(c, "R7_overflow");
      c = '0; c.t0 = 1; drive(c, "R7_sticky");
      do_reset("R7_R8_clear");
      c = '0; c.twb = 1; drive(c, "R8_after_reset");
      // random patterns
      for (int r = 0; r < 40; r++) begin
         c = cfg_t'({$urandom, $urandom});
         c.skip = 25'($urandom & $urandom);
         drive(c, "R10_random");
         if (r == 20) do_reset("R8_mid_reset");
      end
      while (q.size() > 0) @(negedge clk);
      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule